// File: doc/BRIEF.md
# Parallel flash command sequence decoder

This block is the command front end of a byte-wide parallel NOR flash with a 19-bit byte address and eight equal 64 KB sectors. It watches the chip-select, write-strobe and output-enable lines, which arrive already synchronized to the block clock. From them it builds bus write cycles and steps through the multi-cycle unlock sequences that authorize an operation. A completed byte program, whole-array erase or single-sector erase produces a one-cycle start pulse with the latched address and data, for an embedded operation engine outside this block.

While that engine reports busy, and during a power-up lockout after reset, completed writes are discarded. The block also keeps an identification mode. In that mode, host reads return a fixed vendor code or device code chosen by the lowest address bit.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write cycle exists only while chip-select is low, write-strobe is low and output-enable is high. It completes in the first cycle in which that condition no longer holds. Strobe activity with output-enable low, or with either strobe high, forms no write.
- R2: The write address is taken in the first clock cycle of the write cycle and the data in its last clock cycle. For a program, op_addr_o and op_data_o show these values.
- R3: The writes 5555h/AAh, 2AAAh/55h, 5555h/A0h and then any address/data raise prog_start_o for exactly one cycle, with op_addr_o and op_data_o taken from the fourth write. Command addresses are compared on bits 14..0 only.
- R4: The writes 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h and 5555h/10h raise chip_erase_start_o for exactly one cycle.
- R5: The same first five writes followed by data 30h at any address raise sector_erase_start_o for one cycle, with sector_o equal to address bits 18..16 of that last write.
- R6: A write whose address or data does not fit the expected next step drops the partial sequence, so the steps that follow it start no operation.
- R7: In identification mode, a read (chip-select low, output-enable low, address bit 1 low) gives id_valid_o = 1 one cycle later. id_data_o is DAh for address bit 0 = 0 and D6h for address bit 0 = 1. Otherwise id_valid_o = 0 and id_data_o = 00h. The valid codes have odd parity over all 8 bits.
- R8: The writes 5555h/AAh, 2AAAh/55h, 5555h/90h enter identification mode (id_mode_o = 1). A single write of F0h at any address leaves it, as do the writes 5555h/AAh, 2AAAh/55h, 5555h/F0h. The one exception is the target write of a program.
- R9: After a start pulse, completed writes are discarded until busy_i has been sampled low. Any write completing while busy_i is high is discarded.
- R10: Writes completing within the first PU_CYCLES clock edges after reset release are discarded.
- R11: After reset, all start pulses, op_addr_o, op_data_o, sector_o, id_mode_o, id_valid_o and id_data_o are zero.
- R12: At most one start output is high in any cycle, and no start output stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip-select, active low, synchronized |
| we_ni | input | 1 | Write strobe, active low, synchronized |
| oe_ni | input | 1 | Output enable, active low, synchronized |
| addr_i | input | 19 | Byte address |
| data_i | input | 8 | Write data |
| busy_i | input | 1 | Embedded operation engine busy |
| prog_start_o | output | 1 | One-cycle byte program start |
| chip_erase_start_o | output | 1 | One-cycle whole-array erase start |
| sector_erase_start_o | output | 1 | One-cycle sector erase start |
| op_addr_o | output | 19 | Address of the last started operation |
| op_data_o | output | 8 | Data of the last started operation |
| sector_o | output | 3 | Sector index of the last sector erase |
| id_mode_o | output | 1 | Identification mode active |
| id_valid_o | output | 1 | Identification code being returned |
| id_data_o | output | 8 | Identification code |

## Verification
The hardest states to reach are the two lockouts. One is a full, correct sequence whose writes complete while the engine is still busy from the previous start. The other is a sequence issued within the power-up window. The bench drives busy from its own engine model: busy rises on every start pulse and stays high long enough for a complete program sequence to be issued inside it. The bench also shortens the power-up window so that a sequence fits right after reset. Skewed strobes move the address and data within one write cycle, and an output-enable-low strobe during a pending program shows that a non-write leaves the sequence state untouched.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int DW = 8;
  localparam int CMD_AW = 15;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_ERS3, S_ERS4, S_ERS5, S_PGM, S_WAIT
  } seq_state_e;

  localparam logic [CMD_AW-1:0] ADDR_A = 15'h5555;
  localparam logic [CMD_AW-1:0] ADDR_B = 15'h2AAA;

  localparam logic [DW-1:0] D_UNL1  = 8'hAA;
  localparam logic [DW-1:0] D_UNL2  = 8'h55;
  localparam logic [DW-1:0] D_PGM   = 8'hA0;
  localparam logic [DW-1:0] D_ERS   = 8'h80;
  localparam logic [DW-1:0] D_CHIP  = 8'h10;
  localparam logic [DW-1:0] D_SECT  = 8'h30;
  localparam logic [DW-1:0] D_IDIN  = 8'h90;
  localparam logic [DW-1:0] D_IDOUT = 8'hF0;
  localparam logic [DW-1:0] ID_MFR  = 8'hDA;
  localparam logic [DW-1:0] ID_DEV  = 8'hD6;
endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture
  import flash_cmd_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          stb_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic act, act_q, stb_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign act = !ce_ni && !we_ni && oe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      stb_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      stb_q <= act_q && !act;
      // address at later falling strobe, data at earlier rising strobe
      if (act && !act_q) addr_q <= addr_i;
      if (act) data_q <= data_i;
    end
  end

  assign stb_o  = stb_q;
  assign addr_o = addr_q;
  assign data_o = data_q;

  a_r1_stb_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_o |=> !stb_o);
  a_r2_addr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && act) |=> $stable(addr_o));
  a_r1_stb_needs_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |=> !stb_o);
endmodule

// File: rtl/flash_pu_inhibit.sv
module flash_pu_inhibit #(
  parameter int PU_CYCLES = 625000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic inhibit_o
);
  localparam int CW = (PU_CYCLES < 2) ? 1 : $clog2(PU_CYCLES + 1);
  localparam logic [CW-1:0] PU_LIM = CW'(PU_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q != PU_LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign inhibit_o = (cnt_q != PU_LIM);

  a_r10_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PU_LIM);
  a_r10_release_final: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inhibit_o |=> !inhibit_o);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 19,
  parameter int SECT_BITS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stb_i,
  input  logic [AW-1:0]        waddr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic                 busy_i,
  input  logic                 inhibit_i,
  output logic                 prog_start_o,
  output logic                 chip_start_o,
  output logic                 sect_start_o,
  output logic [AW-1:0]        op_addr_o,
  output logic [DW-1:0]        op_data_o,
  output logic [SECT_BITS-1:0] sector_o,
  output logic                 id_mode_o
);
  seq_state_e state_q;
  logic prog_q, chip_q, sect_q, id_q;
  logic [AW-1:0] op_addr_q;
  logic [DW-1:0] op_data_q;
  logic [SECT_BITS-1:0] sector_q;
  logic at_a, at_b, take;

  assign at_a = (waddr_i[CMD_AW-1:0] == ADDR_A);
  assign at_b = (waddr_i[CMD_AW-1:0] == ADDR_B);
  assign take = stb_i && !busy_i && !inhibit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      prog_q    <= 1'b0;
      chip_q    <= 1'b0;
      sect_q    <= 1'b0;
      id_q      <= 1'b0;
      op_addr_q <= '0;
      op_data_q <= '0;
      sector_q  <= '0;
    end else begin
      prog_q <= 1'b0;
      chip_q <= 1'b0;
      sect_q <= 1'b0;
      if (state_q == S_WAIT) begin
        if (!busy_i) state_q <= S_IDLE;
      end else if (take) begin
        if (wdata_i == D_IDOUT && state_q != S_PGM) begin
          id_q    <= 1'b0;
          state_q <= S_IDLE;
        end else begin
          unique case (state_q)
            S_IDLE: state_q <= (at_a && wdata_i == D_UNL1) ? S_UNL1 : S_IDLE;
            S_UNL1: state_q <= (at_b && wdata_i == D_UNL2) ? S_UNL2 : S_IDLE;
            S_UNL2: begin
              state_q <= S_IDLE;
              if (at_a && wdata_i == D_PGM) state_q <= S_PGM;
              else if (at_a && wdata_i == D_ERS) state_q <= S_ERS3;
              else if (at_a && wdata_i == D_IDIN) id_q <= 1'b1;
            end
            S_ERS3: state_q <= (at_a && wdata_i == D_UNL1) ? S_ERS4 : S_IDLE;
            S_ERS4: state_q <= (at_b && wdata_i == D_UNL2) ? S_ERS5 : S_IDLE;
            S_ERS5: begin
              state_q <= S_IDLE;
              if (at_a && wdata_i == D_CHIP) begin
                chip_q    <= 1'b1;
                op_addr_q <= waddr_i;
                op_data_q <= wdata_i;
                state_q   <= S_WAIT;
              end else if (wdata_i == D_SECT) begin
                sect_q    <= 1'b1;
                sector_q  <= waddr_i[AW-1 -: SECT_BITS];
                op_addr_q <= waddr_i;
                op_data_q <= wdata_i;
                state_q   <= S_WAIT;
              end
            end
            S_PGM: begin
              prog_q    <= 1'b1;
              op_addr_q <= waddr_i;
              op_data_q <= wdata_i;
              state_q   <= S_WAIT;
            end
            default: state_q <= S_IDLE;
          endcase
        end
      end
    end
  end

  assign prog_start_o = prog_q;
  assign chip_start_o = chip_q;
  assign sect_start_o = sect_q;
  assign op_addr_o    = op_addr_q;
  assign op_data_o    = op_data_q;
  assign sector_o     = sector_q;
  assign id_mode_o    = id_q;

  a_r12_start_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({prog_q, chip_q, sect_q}));
  a_r12_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_q || chip_q || sect_q) |=> !(prog_q || chip_q || sect_q));
  a_r9_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(prog_q || chip_q || sect_q));
  a_r10_inhibit_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> !(prog_q || chip_q || sect_q));
  a_r9_wait_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prog_q || chip_q || sect_q) |-> state_q == S_WAIT);
endmodule

// File: rtl/flash_id_read.sv
module flash_id_read
  import flash_cmd_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          id_mode_i,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic [1:0]    addr_lo_i,
  output logic          id_valid_o,
  output logic [DW-1:0] id_data_o
);
  logic hit, valid_q;
  logic [DW-1:0] data_q;

  assign hit = id_mode_i && !ce_ni && !oe_ni && !addr_lo_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= hit;
      data_q  <= hit ? (addr_lo_i[0] ? ID_DEV : ID_MFR) : '0;
    end
  end

  assign id_valid_o = valid_q;
  assign id_data_o  = data_q;

  a_r7_odd_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |-> ($countones(id_data_o) % 2) == 1);
  a_r7_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_o |-> id_data_o == '0);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int AW = 19,
  parameter int SECT_BITS = 3,
  parameter int PU_CYCLES = 625000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ce_ni,
  input  logic                 we_ni,
  input  logic                 oe_ni,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        data_i,
  input  logic                 busy_i,
  output logic                 prog_start_o,
  output logic                 chip_erase_start_o,
  output logic                 sector_erase_start_o,
  output logic [AW-1:0]        op_addr_o,
  output logic [DW-1:0]        op_data_o,
  output logic [SECT_BITS-1:0] sector_o,
  output logic                 id_mode_o,
  output logic                 id_valid_o,
  output logic [DW-1:0]        id_data_o
);
  logic          wr_stb, inhibit;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  flash_wr_capture #(.AW(AW)) u_cap (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .stb_o(wr_stb), .addr_o(wr_addr), .data_o(wr_data)
  );

  flash_pu_inhibit #(.PU_CYCLES(PU_CYCLES)) u_pu (
    .clk_i, .rst_ni, .inhibit_o(inhibit)
  );

  flash_seq_fsm #(.AW(AW), .SECT_BITS(SECT_BITS)) u_fsm (
    .clk_i, .rst_ni,
    .stb_i(wr_stb), .waddr_i(wr_addr), .wdata_i(wr_data),
    .busy_i, .inhibit_i(inhibit),
    .prog_start_o, .chip_start_o(chip_erase_start_o),
    .sect_start_o(sector_erase_start_o),
    .op_addr_o, .op_data_o, .sector_o, .id_mode_o
  );

  flash_id_read u_id (
    .clk_i, .rst_ni, .id_mode_i(id_mode_o), .ce_ni, .oe_ni,
    .addr_lo_i(addr_i[1:0]), .id_valid_o, .id_data_o
  );
endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int PU = 60;
  localparam int BUSY_LEN = 30;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce = 1'b1, we = 1'b1, oe = 1'b1, busy = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  data = '0;
  logic prog_s, chip_s, sect_s, id_mode, id_valid;
  logic [18:0] op_addr;
  logic [7:0]  op_data, id_data;
  logic [2:0]  sector;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.PU_CYCLES(PU)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce), .we_ni(we), .oe_ni(oe),
    .addr_i(addr), .data_i(data), .busy_i(busy),
    .prog_start_o(prog_s), .chip_erase_start_o(chip_s),
    .sector_erase_start_o(sect_s), .op_addr_o(op_addr), .op_data_o(op_data),
    .sector_o(sector), .id_mode_o(id_mode), .id_valid_o(id_valid),
    .id_data_o(id_data)
  );

  int n_chk = 0, n_fail = 0;
  int n_prog = 0, n_chip = 0, n_sect = 0;
  int busy_cnt = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int edges;
  bit m_act, m_stb, m_wait, m_id;
  logic [18:0] m_ca; logic [7:0] m_cd;
  logic [18:0] qa[6]; logic [7:0] qd[6]; int qn;
  bit e_p, e_c, e_s, e_idv;
  logic [18:0] e_a; logic [7:0] e_d, e_idd; logic [2:0] e_sec;

  task automatic m_apply(logic [18:0] a, logic [7:0] d);
    bit ok;
    bit lo_a, lo_b;
    lo_a = (a[14:0] == 15'h5555);
    lo_b = (a[14:0] == 15'h2AAA);
    if (d == 8'hF0 && !(qn == 3 && qd[2] == 8'hA0)) begin
      m_id = 0; qn = 0; return;
    end
    qa[qn] = a; qd[qn] = d; qn++;
    ok = 0;
    case (qn)
      1: ok = lo_a && d == 8'hAA;
      2: ok = lo_b && d == 8'h55;
      3: begin
        if (lo_a && d == 8'h90) begin m_id = 1; qn = 0; return; end
        ok = lo_a && (d == 8'hA0 || d == 8'h80);
      end
      4: begin
        if (qd[2] == 8'hA0) begin
          e_p = 1; e_a = a; e_d = d; m_wait = 1; qn = 0; return;
        end
        ok = lo_a && d == 8'hAA;
      end
      5: ok = lo_b && d == 8'h55;
      6: begin
        if (lo_a && d == 8'h10) begin
          e_c = 1; e_a = a; e_d = d; m_wait = 1;
        end else if (d == 8'h30) begin
          e_s = 1; e_a = a; e_d = d; e_sec = a[18:16]; m_wait = 1;
        end
        qn = 0; return;
      end
      default: ok = 0;
    endcase
    if (!ok) qn = 0;
  endtask

  always @(posedge clk) begin
    bit act;
    if (!rst_ni) begin
      edges = 0; m_act = 0; m_stb = 0; m_wait = 0; m_id = 0;
      m_ca = '0; m_cd = '0; qn = 0;
      e_p = 0; e_c = 0; e_s = 0; e_idv = 0;
      e_a = '0; e_d = '0; e_idd = '0; e_sec = '0;
    end else begin
      edges++;
      act = !ce && !we && oe;
      e_idv = m_id && !ce && !oe && !addr[1];
      e_idd = e_idv ? (addr[0] ? 8'hD6 : 8'hDA) : 8'h00;
      e_p = 0; e_c = 0; e_s = 0;
      if (m_wait) begin
        if (!busy) m_wait = 0;
      end else if (m_stb && !busy && (edges - 1) >= PU) begin
        m_apply(m_ca, m_cd);
      end
      m_stb = m_act && !act;
      if (act && !m_act) m_ca = addr;
      if (act) m_cd = data;
      m_act = act;
    end
  end

  // per-cycle comparison, pulse counters, busy engine
  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R3 prog_start", prog_s, e_p);
      chk("R4 chip_start", chip_s, e_c);
      chk("R5 sector_start", sect_s, e_s);
      chk("R2 op_addr", op_addr, e_a);
      chk("R2 op_data", op_data, e_d);
      chk("R5 sector", sector, e_sec);
      chk("R8 id_mode", id_mode, m_id);
      chk("R7 id_valid", id_valid, e_idv);
      chk("R7 id_data", id_data, e_idd);
      chk("R12 onehot", int'(prog_s) + int'(chip_s) + int'(sect_s) <= 1, 1);
      if (prog_s) n_prog++;
      if (chip_s) n_chip++;
      if (sect_s) n_sect++;
      if (prog_s || chip_s || sect_s) busy_cnt = BUSY_LEN;
      else if (busy_cnt > 0) busy_cnt--;
      busy = (busy_cnt > 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [18:0] a, logic [7:0] d, logic oe_v = 1'b1);
    @(negedge clk); addr = a; data = d; ce = 0; we = 0; oe = oe_v;
    repeat (2) @(negedge clk);
    ce = 1; we = 1; oe = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic unlock();
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'h55);
  endtask

  task automatic counts(string tag, int p, int c, int s);
    repeat (3) @(negedge clk); #1;
    chk({tag, " prog count"}, n_prog, p);
    chk({tag, " chip count"}, n_chip, c);
    chk({tag, " sector count"}, n_sect, s);
    n_prog = 0; n_chip = 0; n_sect = 0;
  endtask

  task automatic idle_wait();
    while (busy_cnt > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic id_rd(string tag, logic [18:0] a, logic v, logic [7:0] d);
    @(negedge clk); addr = a; ce = 0; oe = 0;
    @(negedge clk); #1;
    chk({tag, " id_valid"}, id_valid, v);
    chk({tag, " id_data"}, id_data, d);
    ce = 1; oe = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 reset prog", prog_s, 0);
    chk("R11 reset chip", chip_s, 0);
    chk("R11 reset sect", sect_s, 0);
    chk("R11 reset op_addr", op_addr, 0);
    chk("R11 reset op_data", op_data, 0);
    chk("R11 reset sector", sector, 0);
    chk("R11 reset id", {id_mode, id_valid, id_data}, 0);
    rst_ni = 1;

    // R10 sequence inside the power-up window
    unlock(); wr(19'h05555, 8'hA0); wr(19'h01000, 8'h11);
    counts("R10 inhibit", 0, 0, 0);
    repeat (PU) @(negedge clk);

    // R3 program with don't-care high bits on command cycles
    wr(19'h7D555, 8'hAA); wr(19'h3AAAA, 8'h55); wr(19'h45555, 8'hA0);
    wr(19'h6ABCD, 8'h5A);
    counts("R3 program", 1, 0, 0);
    chk("R3 op_addr", op_addr, 19'h6ABCD);
    chk("R3 op_data", op_data, 8'h5A);

    // R9 full sequence while busy
    unlock(); wr(19'h05555, 8'hA0); wr(19'h00123, 8'h33);
    counts("R9 busy ignore", 0, 0, 0);
    idle_wait();

    // R4 chip erase
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h05555, 8'h10);
    counts("R4 chip erase", 0, 1, 0);
    idle_wait();

    // R5 sector erase
    unlock(); wr(19'h05555, 8'h80); unlock(); wr(19'h51234, 8'h30);
    counts("R5 sector erase", 0, 0, 1);
    chk("R5 sector index", sector, 3'd5);
    idle_wait();

    // R6 wrong data mid-sequence, then remainder
    wr(19'h05555, 8'hAA); wr(19'h02AAA, 8'hAA); wr(19'h02AAA, 8'h55);
    wr(19'h05555, 8'hA0); wr(19'h01234, 8'h77);
    counts("R6 wrong data", 0, 0, 0);
    // R6 wrong address on second unlock of erase
    unlock(); wr(19'h05555, 8'h80); wr(19'h05555, 8'hAA); wr(19'h05555, 8'h55);
    wr(19'h05555, 8'h10);
    counts("R6 wrong address", 0, 0, 0);
    // R6 out of order
    wr(19'h05555, 8'hA0); wr(19'h00042, 8'h42);
    counts("R6 out of order", 0, 0, 0);

    // R1 output-enable low and write-strobe high are not writes
    unlock(); wr(19'h05555, 8'hA0);
    wr(19'h00077, 8'h99, 1'b0);
    @(negedge clk); addr = 19'h00066; data = 8'h66; ce = 0; we = 1;
    repeat (3) @(negedge clk); ce = 1;
    counts("R1 non-write", 0, 0, 0);
    // R2 skewed cycle: address moves and data moves inside the write
    @(negedge clk); addr = 19'h12345; data = 8'h01; ce = 0;
    @(negedge clk); we = 0;
    @(negedge clk); addr = 19'h7FFFF;
    @(negedge clk); data = 8'hC3;
    @(negedge clk); we = 1; ce = 1;
    repeat (2) @(negedge clk);
    counts("R1 pending program kept", 1, 0, 0);
    chk("R2 first-cycle addr", op_addr, 19'h12345);
    chk("R2 last-cycle data", op_data, 8'hC3);
    idle_wait();

    // R7 / R8 identification mode
    id_rd("R7 no id mode", 19'h00000, 0, 8'h00);
    unlock(); wr(19'h05555, 8'h90);
    repeat (2) @(negedge clk);
    chk("R8 id entry", id_mode, 1);
    id_rd("R7 vendor code", 19'h70000, 1, 8'hDA);
    id_rd("R7 device code", 19'h00001, 1, 8'hD6);
    id_rd("R7 A1 high", 19'h00002, 0, 8'h00);
    wr(19'h31234, 8'hF0);
    repeat (2) @(negedge clk);
    chk("R8 single exit", id_mode, 0);
    id_rd("R8 after exit", 19'h00000, 0, 8'h00);
    unlock(); wr(19'h05555, 8'h90);
    unlock(); wr(19'h05555, 8'hF0);
    repeat (2) @(negedge clk);
    chk("R8 unlock exit", id_mode, 0);

    // R12 back-to-back program after busy
    unlock(); wr(19'h05555, 8'hA0); wr(19'h00010, 8'hF0);
    counts("R12 single pulse", 1, 0, 0);
    idle_wait();

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule